// File: doc/BRIEF.md
# Calendar Timekeeping Counter

This block keeps wall-clock time and the calendar in BCD. A one-cycle enable, asserted once per oscillator period of the 32.768 kHz timebase, feeds a prescaler. The prescaler issues one second step every `PRESCALE` enabled cycles. That step ripples through seconds, minutes, hours, day of week, date, month, year and a century byte. The date follows the length of each month and the leap-year rule. The hour field can run in 24-hour form or in 12-hour form with a PM flag.

A host loads any field through a byte-wide write port. It reads the fields through a snapshot bank. A latch pulse copies every field at once, so a carry during a multi-byte read cannot mix old and new values. After reset the counter stays frozen until the host writes any field. Every write restarts the prescaler, so the first step after a write comes one full second later.

Field addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century. The hour byte uses bit 7 as the mode bit (1 = 24-hour, 0 = 12-hour). In 24-hour form bits 5:0 hold BCD 00–23. In 12-hour form bit 5 is the PM flag and bits 4:0 hold BCD 01–12. Bit 6 is always stored as 0.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset no field changes, whatever `tick_en` does, until the first write to any address 0–7. From then on the counter runs.
- R2: One second step occurs on every `PRESCALE`-th cycle with `tick_en` high, and cycles with `tick_en` low are not counted. A write clears the prescaler, so the next step comes on the `PRESCALE`-th enabled cycle after the write edge.
- R3: Seconds and minutes count BCD 00–59. Seconds 59 wrap to 00 and carry into minutes, and minutes 59 with that carry wrap to 00 and step the hour.
- R4: In 24-hour mode the hour counts BCD 00–23, and the step from 23:59:59 gives hour byte 0x80 plus one day carry.
- R5: In 12-hour mode the hour goes 12, 01 … 11. At 11→12 the PM flag (bit 5) toggles, and the day carry happens only when 11 PM becomes 12 AM. The mode bit never changes except by a write.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. A wrap steps the month, and month 12 wraps to 01 and steps the year.
- R7: February ends at 29 in a leap year and at 28 otherwise. Years 01–99 are leap when divisible by 4, and year 00 is leap only when the century value is divisible by 4.
- R8: Year 99 wraps to 00 and increments the century byte.
- R9: Day of week counts 0–6, steps once at each midnight carry, wraps 6→0, and does not move on any other step.
- R10: `rd_data` shows the field at `rd_addr` as latched by the last `rd_latch` pulse. It keeps that value while the live counters move.
- R11: Reset values are 00 seconds, 00 minutes, hour byte 0x80, date 01, month 01, year 00, day 0 and century `RESET_CENT` (default 0x20).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One pulse per timebase oscillator cycle |
| wr_en | input | 1 | Write strobe for one field |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | BCD byte to load |
| rd_latch | input | 1 | Copies all fields into the snapshot bank |
| rd_addr | input | 3 | Field address for a read |
| rd_data | output | 8 | Snapshot byte at `rd_addr` |

## Verification
A wrong carry decision shows at the next second step whose carry chain reaches the faulty field. It appears as a wrong byte in the first snapshot taken after that step. Such faults sit deep in the chain: a bad month-length or leap decision shows only at a month end, and a bad century step only at year 99. For that reason every case loads the fields one second before a boundary. A prescaler fault shows as a step one enabled cycle early or late, or a step during a `tick_en` gap. The cases sample on both sides of the expected step edge, so such a fault appears as an off-by-one second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      FLD_SEC   = 3'd0,
      FLD_MIN   = 3'd1,
      FLD_HOUR  = 3'd2,
      FLD_DATE  = 3'd3,
      FLD_MONTH = 3'd4,
      FLD_YEAR  = 3'd5,
      FLD_DOW   = 3'd6,
      FLD_CENT  = 3'd7
   } fld_e;

   localparam int unsigned NUM_FIELDS = 8;
   localparam int unsigned FIELD_W    = 8;

   // Next BCD value for a two-digit byte (caller handles the upper wrap)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   // Last valid date of a month, in BCD
   function automatic logic [7:0] month_last(input logic [7:0] month, input logic leap);
      case (month)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned PRESCALE = 32768,
   localparam int unsigned CNT_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             clear,
   output logic             sec_tick,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] LAST  = CNT_W'(PRESCALE - 1);
   localparam bit               IS_P2 = ((PRESCALE & (PRESCALE - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic             at_last;

   generate
      if (PRESCALE < 2) begin : g_bad
         $error("rtc_prescaler: PRESCALE must be at least 2");
      end
      if (IS_P2) begin : g_pow2
         // natural wrap of a full-range counter
         assign at_last  = (cnt_q == LAST);
         assign cnt_next = cnt_q + CNT_W'(1);
      end else begin : g_cmp
         assign at_last  = (cnt_q == LAST);
         assign cnt_next = at_last ? '0 : cnt_q + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clear)            cnt_q <= '0;
      else if (run && tick_en)   cnt_q <= cnt_next;
   end

   assign sec_tick = run && tick_en && at_last && !clear;
   assign cnt      = cnt_q;

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_q,
   output logic [7:0] min_q,
   output logic [7:0] hour_q,
   output logic [7:0] dow_q,
   output logic       day_roll
);

   logic       sec_end, min_end, hour_adv, midnight;
   logic [7:0] hour_nxt, inc24, inc12, h12;

   assign sec_end  = (sec_q >= 8'h59);
   assign min_end  = (min_q >= 8'h59);
   assign hour_adv = sec_tick && sec_end && min_end;

   assign inc24 = bcd_inc({2'b00, hour_q[5:0]});
   assign h12   = {3'b000, hour_q[4:0]};
   assign inc12 = bcd_inc(h12);

   always_comb begin
      hour_nxt = hour_q;
      midnight = 1'b0;
      if (hour_q[7]) begin
         if (hour_q[5:0] >= 6'h23) begin
            hour_nxt = 8'h80;
            midnight = 1'b1;
         end else begin
            hour_nxt = {2'b10, inc24[5:0]};
         end
      end else begin
         if (h12 == 8'h11) begin
            hour_nxt = {2'b00, ~hour_q[5], 5'h12};
            midnight = hour_q[5];
         end else if (h12 >= 8'h12) begin
            hour_nxt = {2'b00, hour_q[5], 5'h01};
         end else begin
            hour_nxt = {2'b00, hour_q[5], inc12[4:0]};
         end
      end
   end

   assign day_roll = hour_adv && midnight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= 8'h00;
         min_q  <= 8'h00;
         hour_q <= 8'h80;
         dow_q  <= 8'h00;
      end else begin
         if (wr_en && wr_addr == FLD_SEC)         sec_q <= wr_data;
         else if (sec_tick)                       sec_q <= sec_end ? 8'h00 : bcd_inc(sec_q);

         if (wr_en && wr_addr == FLD_MIN)         min_q <= wr_data;
         else if (sec_tick && sec_end)            min_q <= min_end ? 8'h00 : bcd_inc(min_q);

         if (wr_en && wr_addr == FLD_HOUR)        hour_q <= wr_data & 8'hBF;
         else if (hour_adv)                       hour_q <= hour_nxt;

         if (wr_en && wr_addr == FLD_DOW)         dow_q <= wr_data;
         else if (day_roll)                       dow_q <= (dow_q >= 8'h06) ? 8'h00 : dow_q + 8'h01;
      end
   end

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
   import rtc_pkg::*;
#(
   parameter logic [7:0] RESET_CENT = 8'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_roll,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] date_q,
   output logic [7:0] month_q,
   output logic [7:0] year_q,
   output logic [7:0] cent_q
);

   logic [6:0] yr_bin, cent_bin;
   logic       leap, month_end, year_end, cent_step;
   logic [7:0] last_date;

   assign yr_bin    = bcd_to_bin(year_q);
   assign cent_bin  = bcd_to_bin(cent_q);
   assign leap      = (year_q == 8'h00) ? (cent_bin[1:0] == 2'b00) : (yr_bin[1:0] == 2'b00);
   assign last_date = month_last(month_q, leap);

   assign month_end = day_roll && (date_q >= last_date);
   assign year_end  = month_end && (month_q >= 8'h12);
   assign cent_step = year_end && (year_q >= 8'h99);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         date_q  <= 8'h01;
         month_q <= 8'h01;
         year_q  <= 8'h00;
         cent_q  <= RESET_CENT;
      end else begin
         if (wr_en && wr_addr == FLD_DATE)        date_q <= wr_data;
         else if (day_roll)                       date_q <= month_end ? 8'h01 : bcd_inc(date_q);

         if (wr_en && wr_addr == FLD_MONTH)       month_q <= wr_data;
         else if (month_end)                      month_q <= year_end ? 8'h01 : bcd_inc(month_q);

         if (wr_en && wr_addr == FLD_YEAR)        year_q <= wr_data;
         else if (year_end)                       year_q <= cent_step ? 8'h00 : bcd_inc(year_q);

         if (wr_en && wr_addr == FLD_CENT)        cent_q <= wr_data;
         else if (cent_step)                      cent_q <= (cent_q >= 8'h99) ? 8'h00 : bcd_inc(cent_q);
      end
   end

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
   parameter int unsigned FIELDS = 8,
   parameter int unsigned W      = 8,
   localparam int unsigned AW    = (FIELDS > 1) ? $clog2(FIELDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic [FIELDS*W-1:0] live,
   input  logic [AW-1:0]     rd_addr,
   output logic [W-1:0]      rd_data
);

   logic [W-1:0] snap [FIELDS];

   generate
      if (FIELDS != (1 << AW)) begin : g_bad
         $error("rtc_snapshot: FIELDS must be a power of two");
      end
      for (genvar i = 0; i < FIELDS; i++) begin : g_fld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     snap[i] <= '0;
            else if (latch) snap[i] <= live[i*W +: W];
         end
      end
   endgenerate

   assign rd_data = snap[rd_addr];

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_pkg::*;
#(
   parameter int unsigned PRESCALE   = 32768,
   parameter logic [7:0]  RESET_CENT = 8'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       rd_latch,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data
);

   localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   logic             run_q;
   logic             sec_tick, day_roll;
   logic [CNT_W-1:0] pre_cnt;
   logic [7:0]       sec_q, min_q, hour_q, dow_q;
   logic [7:0]       date_q, month_q, year_q, cent_q;
   logic [NUM_FIELDS*FIELD_W-1:0] live;

   // Frozen after reset until the host loads any field
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= 1'b0;
      else if (wr_en) run_q <= 1'b1;
   end

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .run      (run_q),
      .clear    (wr_en),
      .sec_tick (sec_tick),
      .cnt      (pre_cnt)
   );

   rtc_time_chain u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sec_q    (sec_q),
      .min_q    (min_q),
      .hour_q   (hour_q),
      .dow_q    (dow_q),
      .day_roll (day_roll)
   );

   rtc_date_chain #(.RESET_CENT(RESET_CENT)) u_date (
      .clk      (clk),
      .rst_n    (rst_n),
      .day_roll (day_roll),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .date_q   (date_q),
      .month_q  (month_q),
      .year_q   (year_q),
      .cent_q   (cent_q)
   );

   assign live = {cent_q, dow_q, year_q, month_q, date_q, hour_q, min_q, sec_q};

   rtc_snapshot #(.FIELDS(NUM_FIELDS), .W(FIELD_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch   (rd_latch),
      .live    (live),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker #(
   parameter int unsigned CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wr_en,
   input logic             rd_latch,
   input logic [2:0]       rd_addr,
   input logic [7:0]       rd_data,
   input logic             run_q,
   input logic             sec_tick,
   input logic             day_roll,
   input logic [CNT_W-1:0] pre_cnt,
   input logic [7:0]       sec_q,
   input logic [7:0]       min_q,
   input logic [7:0]       hour_q,
   input logic [7:0]       dow_q,
   input logic [7:0]       date_q
);

   a_r1_frozen_until_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(date_q)));

   a_r1_no_step_while_held: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !sec_tick);

   a_r2_write_clears_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (pre_cnt == '0));

   a_r2_step_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> tick_en);

   a_r3_quiet_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !wr_en) |=> $stable(sec_q));

   a_r4_day_carry_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      day_roll |-> sec_tick);

   a_r5_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(hour_q[7]));

   a_r9_dow_moves_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
      (day_roll && !wr_en) |=> !$stable(dow_q));

   a_r10_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_latch && $stable(rd_addr)) |=> $stable(rd_data));

endmodule

bind rtc_calendar_core rtc_calendar_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .wr_en    (wr_en),
   .rd_latch (rd_latch),
   .rd_addr  (rd_addr),
   .rd_data  (rd_data),
   .run_q    (run_q),
   .sec_tick (sec_tick),
   .day_roll (day_roll),
   .pre_cnt  (pre_cnt),
   .sec_q    (sec_q),
   .min_q    (min_q),
   .hour_q   (hour_q),
   .dow_q    (dow_q),
   .date_q   (date_q)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;

   localparam int unsigned PS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rd_latch = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [63:0] got;

   always #4 clk = ~clk;

   rtc_calendar_core #(.PRESCALE(PS), .RESET_CENT(8'h20)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_latch(rd_latch), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // packed order: {cent, dow, year, month, date, hour, min, sec}, field i at bits i*8
   task automatic chk(input string tag, input int fld, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s field %0d: actual %02h expected %02h", tag, fld, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [63:0] exp);
      for (int i = 0; i < 8; i++) chk(tag, i, got[i*8 +: 8], exp[i*8 +: 8]);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic set_clock(input logic [63:0] v);
      for (int i = 7; i >= 0; i--) wr(3'(i), v[i*8 +: 8]);
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic peek();
      for (int i = 0; i < 8; i++) begin
         rd_addr = 3'(i);
         #1 got[i*8 +: 8] = rd_data;
      end
   endtask

   task automatic latch();
      @(negedge clk);
      rd_latch = 1'b1;
      @(posedge clk);
      #1 rd_latch = 1'b0;
   endtask

   task automatic read_all();
      latch();
      peek();
   endtask

   // load a state, let n seconds pass, snapshot and compare
   task automatic step_case(input string tag, input logic [63:0] start, input int n, input logic [63:0] exp);
      set_clock(start);
      wait_edges(n * PS);
      read_all();
      chk_all(tag, exp);
   endtask

   task automatic t_reset_and_hold();
      read_all();
      chk_all("R11 reset values", 64'h20_00_00_01_01_80_00_00);
      wait_edges(40);
      read_all();
      chk_all("R1 frozen before first write", 64'h20_00_00_01_01_80_00_00);
   endtask

   task automatic t_prescaler();
      @(negedge clk) tick_en = 1'b0;
      set_clock(64'h20_02_24_03_15_90_00_10);
      wait_edges(20);
      read_all();
      chk("R2 no step while tick_en low", 0, got[7:0], 8'h10);
      @(negedge clk) tick_en = 1'b1;
      wr(3'd0, 8'h10);
      wait_edges(PS - 1);
      read_all();
      chk("R2 no step before full period", 0, got[7:0], 8'h10);
      wr(3'd0, 8'h10);
      wait_edges(PS);
      read_all();
      chk("R2 R1 step after full period", 0, got[7:0], 8'h11);
   endtask

   task automatic t_minutes();
      step_case("R3 minute and hour carry 24h",
                64'h20_02_24_03_15_92_59_58, 2, 64'h20_02_24_03_15_93_00_00);
   endtask

   task automatic t_midnight24();
      step_case("R4 R9 midnight 24h",
                64'h20_03_24_06_15_A3_59_59, 1, 64'h20_04_24_06_16_80_00_00);
   endtask

   task automatic t_twelve_hour();
      step_case("R5 11 AM to 12 PM",
                64'h20_03_24_06_15_11_59_59, 1, 64'h20_03_24_06_15_32_00_00);
      step_case("R5 12 PM to 1 PM",
                64'h20_03_24_06_15_32_59_59, 1, 64'h20_03_24_06_15_21_00_00);
      step_case("R5 11 PM to 12 AM next day",
                64'h20_03_24_06_15_31_59_59, 1, 64'h20_04_24_06_16_12_00_00);
   endtask

   task automatic t_months();
      step_case("R6 April ends at 30",
                64'h20_01_24_04_30_A3_59_59, 1, 64'h20_02_24_05_01_80_00_00);
      step_case("R6 May reaches 31",
                64'h20_01_24_05_30_A3_59_59, 1, 64'h20_02_24_05_31_80_00_00);
      step_case("R6 December wraps the year",
                64'h20_01_24_12_31_A3_59_59, 1, 64'h20_02_25_01_01_80_00_00);
   endtask

   task automatic t_leap();
      step_case("R7 leap year Feb 29",
                64'h20_01_24_02_28_A3_59_59, 1, 64'h20_02_24_02_29_80_00_00);
      step_case("R7 leap year Mar 01",
                64'h20_01_24_02_29_A3_59_59, 1, 64'h20_02_24_03_01_80_00_00);
      step_case("R7 common year Mar 01",
                64'h20_01_23_02_28_A3_59_59, 1, 64'h20_02_23_03_01_80_00_00);
      step_case("R7 year 00 century 20 leap",
                64'h20_01_00_02_28_A3_59_59, 1, 64'h20_02_00_02_29_80_00_00);
      step_case("R7 year 00 century 21 common",
                64'h21_01_00_02_28_A3_59_59, 1, 64'h21_02_00_03_01_80_00_00);
   endtask

   task automatic t_century();
      step_case("R8 year 99 steps century",
                64'h20_05_99_12_31_A3_59_59, 1, 64'h21_06_00_01_01_80_00_00);
   endtask

   task automatic t_dow_wrap();
      step_case("R9 day of week 6 wraps to 0",
                64'h20_06_24_06_15_A3_59_59, 1, 64'h20_00_24_06_16_80_00_00);
   endtask

   task automatic t_snapshot();
      set_clock(64'h20_05_99_12_31_A3_59_59);
      wait_edges(PS - 2);
      latch();
      wait_edges(3);
      peek();
      chk_all("R10 snapshot kept across carry", 64'h20_05_99_12_31_A3_59_59);
      read_all();
      chk_all("R10 new snapshot after carry", 64'h21_06_00_01_01_80_00_00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset_and_hold();
      t_prescaler();
      t_minutes();
      t_midnight24();
      t_twelve_hour();
      t_months();
      t_leap();
      t_century();
      t_dow_wrap();
      t_snapshot();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule